// File: doc/BRIEF.md
# Code Histogram Engine

The engine builds an occurrence histogram of converter output codes in an internal synchronous memory that holds one counter per possible code. A start command launches a run. The memory is swept to zero first. After that, every valid sample adds one to the counter whose address equals the sample's code. The run halts on the first sample that brings any single counter up to a ceiling, and the ceiling is picked by a two-bit select.

Once the run halts, a data-available flag rises. A reader then walks the counters in ascending code order, one request at a time. The flag drops when the highest code's counter has been delivered. The code width is a parameter, so the same engine serves 12-bit converter codes and wider 15-bit data. Counters are 24 bits wide, so none can wrap before the ceiling is seen.

Increments use a two-stage read-modify-write on a simple dual-port memory. A counter value is forwarded to the next sample when back-to-back samples carry the same code, so no occurrence is lost at full sample rate.

Top module: `hist_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `data_avail` and `rd_valid` are low.
- R2: When `start` is accepted in idle, `busy` is high from the next cycle. A clear pass of exactly 2^CODE_W cycles sets every counter to zero, including counts left from an earlier run. A sample sampled on the clock edge that ends the clear pass is still part of that pass. The first sample that can count is the one sampled on the following edge.
- R3: During counting, each cycle with `smp_valid` high adds exactly one to the counter at address `smp_code`. This holds for back-to-back samples of the same code, alternating codes and spaced samples.
- R4: The run halts on the sample that brings a counter to the ceiling. That counter ends exactly at the ceiling, and no counter ever exceeds it. `data_avail` rises two clock edges after that sample is sampled, and `busy` falls on the same edge.
- R5: The ceiling is taken from `max_sel` when `start` is accepted and is held for the whole run: 2'b00 gives 16384, 2'b01 gives 2048, 2'b10 gives 4096 and 2'b11 gives 8192.
- R6: While `data_avail` is high, each `rd_next` pulse yields, two edges later, one cycle of `rd_valid` with `rd_bin` and `rd_count` for the next code. Codes are delivered in ascending order starting at 0. `rd_next` has no effect in idle.
- R7: `data_avail` stays high until the counter for the highest code is delivered. It falls on the same edge that raises `rd_valid` for that code. `busy` and `data_avail` are never high together.
- R8: Samples presented during the clear pass or after the halt change no counter. `start` and changes of `max_sel` while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run (accepted in idle or during readout) |
| max_sel | input | 2 | Ceiling select, sampled with start |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | CODE_W | Sample code (bin address) |
| rd_next | input | 1 | Request the next counter during readout |
| busy | output | 1 | Clear pass or counting in progress |
| data_avail | output | 1 | Histogram ready and not yet fully read |
| rd_valid | output | 1 | One-cycle strobe for rd_bin and rd_count |
| rd_bin | output | CODE_W | Code of the delivered counter |
| rd_count | output | BIN_W | Value of the delivered counter |

## Verification
A missed forward in the increment pipeline loses a count at the first back-to-back pair of equal codes. This stays hidden until readout, where that bin comes out one low and the halt lands a sample late. A clear pass one cycle short or long shows at once as a leftover count or a lost first sample in the bins the bench reads back. A wrong ceiling or a late stop shows as a halting bin above or below the selected value. A readout pointer fault shows on the very next `rd_valid` as a wrong `rd_bin`, or as `data_avail` falling too early or too late.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_COUNT = 2'd2,
    ST_READ  = 2'd3
  } hist_state_e;

  // Ceiling from the two-bit select: 0 -> base*8, 1 -> base, 2 -> base*2, 3 -> base*4
  function automatic int unsigned ceiling_of(input logic [1:0] sel, input int unsigned base_log2);
    int unsigned sh;
    if (sel == 2'd0) sh = base_log2 + 3;
    else             sh = base_log2 + int'(sel) - 1;
    return 32'd1 << sh;
  endfunction

endpackage

// File: rtl/hist_bin_ram.sv
module hist_bin_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read, old data on a same-address collision
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end

endmodule

// File: rtl/hist_accum.sv
module hist_accum #(
  parameter int CODE_W = 12,
  parameter int BIN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [BIN_W-1:0]  cap,
  input  logic [BIN_W-1:0]  ram_q,
  output logic              rd_en,
  output logic [CODE_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_addr,
  output logic [BIN_W-1:0]  wr_data,
  output logic              hit
);
  logic              s1_v;
  logic [CODE_W-1:0] s1_code;
  logic              s2_v;
  logic [CODE_W-1:0] s2_code;
  logic [BIN_W-1:0]  s2_cnt;
  logic [BIN_W-1:0]  base;
  logic [BIN_W-1:0]  incr;
  logic              accept;

  // The memory read for s1 missed the write made one edge earlier: take that value instead
  always_comb begin
    base    = (s2_v && (s2_code == s1_code)) ? s2_cnt : ram_q;
    incr    = base + 1'b1;
    hit     = s1_v && (incr == cap);
    accept  = en && smp_valid && !hit;
    rd_en   = accept;
    rd_addr = smp_code;
    wr_en   = s1_v;
    wr_addr = s1_code;
    wr_data = incr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      s1_code <= '0;
      s2_code <= '0;
      s2_cnt  <= '0;
    end else begin
      s1_v    <= accept;
      s1_code <= smp_code;
      s2_v    <= s1_v;
      s2_code <= s1_code;
      s2_cnt  <= incr;
    end
  end

endmodule

// File: rtl/hist_readout.sv
module hist_readout #(
  parameter int CODE_W = 12,
  parameter int BIN_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              active,
  input  logic              rd_next,
  input  logic [BIN_W-1:0]  ram_q,
  output logic              rd_en,
  output logic [CODE_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CODE_W-1:0] rd_bin,
  output logic [BIN_W-1:0]  rd_count,
  output logic              drained
);
  logic [CODE_W-1:0] ptr;
  logic              exhausted;
  logic              p1_v;
  logic [CODE_W-1:0] p1_bin;
  logic              take;

  always_comb begin
    take    = active && rd_next && !exhausted;
    rd_en   = take;
    rd_addr = ptr;
    drained = p1_v && (p1_bin == {CODE_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr       <= '0;
      exhausted <= 1'b0;
      p1_v      <= 1'b0;
      p1_bin    <= '0;
      rd_valid  <= 1'b0;
      rd_bin    <= '0;
      rd_count  <= '0;
    end else begin
      if (take) begin
        ptr <= ptr + 1'b1;
        if (ptr == {CODE_W{1'b1}}) exhausted <= 1'b1;
      end
      p1_v     <= take;
      p1_bin   <= ptr;
      rd_valid <= p1_v;
      if (p1_v) begin
        rd_bin   <= p1_bin;
        rd_count <= ram_q;
      end
    end
  end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int CODE_W        = 12,
  parameter int BIN_W         = 24,
  parameter int CAP_BASE_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        max_sel,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic              rd_next,
  output logic              busy,
  output logic              data_avail,
  output logic              rd_valid,
  output logic [CODE_W-1:0] rd_bin,
  output logic [BIN_W-1:0]  rd_count
);
  localparam logic [CODE_W-1:0] LAST_ADDR = {CODE_W{1'b1}};

  hist_state_e       state_q, state_nxt;
  logic [CODE_W-1:0] clr_ptr;
  logic [BIN_W-1:0]  cap_q;
  logic              begin_run;

  logic              ram_we, ram_re;
  logic [CODE_W-1:0] ram_wa, ram_ra;
  logic [BIN_W-1:0]  ram_wd, ram_q;

  logic              acc_re, acc_we, acc_hit;
  logic [CODE_W-1:0] acc_ra, acc_wa;
  logic [BIN_W-1:0]  acc_wd;

  logic              rdo_re, rdo_drained;
  logic [CODE_W-1:0] rdo_ra;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_nxt = ST_CLEAR;
      ST_CLEAR: if (clr_ptr == LAST_ADDR) state_nxt = ST_COUNT;
      ST_COUNT: if (acc_hit) state_nxt = ST_READ;
      ST_READ: begin
        if (start)            state_nxt = ST_CLEAR;
        else if (rdo_drained) state_nxt = ST_IDLE;
      end
      default:  state_nxt = ST_IDLE;
    endcase
    begin_run = (state_nxt == ST_CLEAR) && (state_q != ST_CLEAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy       <= 1'b0;
      data_avail <= 1'b0;
      clr_ptr    <= '0;
      cap_q      <= '0;
    end else begin
      state_q    <= state_nxt;
      busy       <= (state_nxt == ST_CLEAR) || (state_nxt == ST_COUNT);
      data_avail <= (state_nxt == ST_READ);
      if (begin_run) begin
        clr_ptr <= '0;
        cap_q   <= BIN_W'(ceiling_of(max_sel, CAP_BASE_LOG2));
      end else if (state_q == ST_CLEAR) begin
        clr_ptr <= clr_ptr + 1'b1;
      end
    end
  end

  // Memory port steering: clear sweep owns the write port, readout owns the read port in ST_READ
  always_comb begin
    if (state_q == ST_CLEAR) begin
      ram_we = 1'b1;
      ram_wa = clr_ptr;
      ram_wd = '0;
    end else begin
      ram_we = acc_we;
      ram_wa = acc_wa;
      ram_wd = acc_wd;
    end
    ram_re = acc_re || rdo_re;
    ram_ra = (state_q == ST_READ) ? rdo_ra : acc_ra;
  end

  hist_bin_ram #(.ADDR_W(CODE_W), .DATA_W(BIN_W)) u_ram (
    .clk (clk),
    .we  (ram_we),
    .wa  (ram_wa),
    .wd  (ram_wd),
    .re  (ram_re),
    .ra  (ram_ra),
    .q   (ram_q)
  );

  hist_accum #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .en        (state_q == ST_COUNT),
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .cap       (cap_q),
    .ram_q     (ram_q),
    .rd_en     (acc_re),
    .rd_addr   (acc_ra),
    .wr_en     (acc_we),
    .wr_addr   (acc_wa),
    .wr_data   (acc_wd),
    .hit       (acc_hit)
  );

  hist_readout #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_readout (
    .clk      (clk),
    .rst      (rst),
    .flush    (begin_run),
    .active   (state_q == ST_READ),
    .rd_next  (rd_next),
    .ram_q    (ram_q),
    .rd_en    (rdo_re),
    .rd_addr  (rdo_ra),
    .rd_valid (rd_valid),
    .rd_bin   (rd_bin),
    .rd_count (rd_count),
    .drained  (rdo_drained)
  );

endmodule

// File: rtl/hist_engine_chk.sv
module hist_engine_chk #(
  parameter int CODE_W = 12,
  parameter int BIN_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_next,
  input logic              busy,
  input logic              data_avail,
  input logic              rd_valid,
  input logic [CODE_W-1:0] rd_bin,
  input logic [BIN_W-1:0]  rd_count,
  input logic [BIN_W-1:0]  cap
);
  logic              rst_q = 1'b0;
  logic [CODE_W-1:0] exp_bin;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || busy) exp_bin <= '0;
    else if (rd_valid) exp_bin <= exp_bin + 1'b1;
  end

  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_quiet_R1: assert (!busy && !data_avail && !rd_valid)
        else $error("outputs active right after reset");
    end
  end

  assert_order_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_bin == exp_bin));

  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_next, 2));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_count <= cap));

  assert_avail_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(data_avail) |-> $past(busy));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy && data_avail));

  assert_avail_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(data_avail) |-> (busy || (rd_valid && (rd_bin == {CODE_W{1'b1}}))));

endmodule

bind hist_engine hist_engine_chk #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_next    (rd_next),
  .busy       (busy),
  .data_avail (data_avail),
  .rd_valid   (rd_valid),
  .rd_bin     (rd_bin),
  .rd_count   (rd_count),
  .cap        (cap_q)
);

// File: tb/tb_hist_engine.sv
`timescale 1ns/1ps
module tb_hist_engine;
  localparam int CODE_W = 12;
  localparam int BIN_W  = 24;
  localparam int DEPTH  = 1 << CODE_W;

  // burst vectors: [28] idle gap after each sample, [27:12] repeat count, [11:0] code
  localparam int NB = 9;
  localparam logic [28:0] RUN1 [NB] = '{
    {1'b0, 16'd3,    12'd5},
    {1'b0, 16'd1,    12'd7},
    {1'b0, 16'd1,    12'd5},
    {1'b0, 16'd1,    12'd7},
    {1'b1, 16'd2,    12'd4095},
    {1'b0, 16'd1,    12'd0},
    {1'b1, 16'd4,    12'd5},
    {1'b0, 16'd2100, 12'd100},
    {1'b0, 16'd5,    12'd200}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [1:0]        max_sel = 2'b00;
  logic              smp_valid = 1'b0;
  logic [CODE_W-1:0] smp_code = '0;
  logic              rd_next = 1'b0;
  logic              busy, data_avail, rd_valid;
  logic [CODE_W-1:0] rd_bin;
  logic [BIN_W-1:0]  rd_count;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  int  exp_cnt [DEPTH];
  int  cap_m;
  bit  halted;
  bit  pend;

  always #2.5 clk = ~clk;

  hist_engine #(.CODE_W(CODE_W), .BIN_W(BIN_W)) dut (
    .clk(clk), .rst(rst), .start(start), .max_sel(max_sel),
    .smp_valid(smp_valid), .smp_code(smp_code), .rd_next(rd_next),
    .busy(busy), .data_avail(data_avail), .rd_valid(rd_valid),
    .rd_bin(rd_bin), .rd_count(rd_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cap_of(input logic [1:0] s);
    case (s)
      2'b00:   return 16384;
      2'b01:   return 2048;
      2'b10:   return 4096;
      default: return 8192;
    endcase
  endfunction

  task automatic pend_check();
    if (pend) begin
      chk(data_avail == 1'b1, "R4", "data_avail two edges after halting sample", data_avail, 1);
      chk(busy == 1'b0, "R4", "busy after halt", busy, 0);
      pend = 1'b0;
    end
  endtask

  task automatic drive_one(input int code, input bit with_start);
    bit now;
    now = 1'b0;
    smp_valid = 1'b1;
    smp_code  = CODE_W'(code);
    start     = with_start;
    if (!halted) begin
      exp_cnt[code]++;
      if (exp_cnt[code] == cap_m) begin
        halted = 1'b1;
        now = 1'b1;
      end
    end
    @(negedge clk);
    start = 1'b0;
    pend_check();
    if (now) begin
      chk(data_avail == 1'b0, "R4", "data_avail one edge after halting sample", data_avail, 0);
      pend = 1'b1;
    end
  endtask

  task automatic idle_one();
    smp_valid = 1'b0;
    @(negedge clk);
    pend_check();
  endtask

  // start a run; optionally drive noise samples through the whole clear pass
  task automatic start_run(input logic [1:0] sel, input bit noise, input int noise_code);
    start   = 1'b1;
    max_sel = sel;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(data_avail == 1'b0, "R2", "data_avail after start", data_avail, 0);
    for (int b = 0; b < DEPTH; b++) exp_cnt[b] = 0;
    cap_m  = cap_of(sel);
    halted = 1'b0;
    pend   = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      smp_valid = noise;
      smp_code  = CODE_W'(noise_code);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int b = 0; b < DEPTH; b++) begin
      rd_next = 1'b1;
      @(negedge clk);
      rd_next = 1'b0;
      @(negedge clk);
      chk(rd_valid == 1'b1 && rd_bin == CODE_W'(b), "R6", {tag, " bin order"}, rd_bin, b);
      chk(rd_count == BIN_W'(exp_cnt[b]), "R3", {tag, " bin count"}, rd_count, exp_cnt[b]);
      if (b < DEPTH - 1)
        chk(data_avail == 1'b1, "R7", {tag, " data_avail held during readout"}, data_avail, 1);
      else
        chk(data_avail == 1'b0 && busy == 1'b0, "R7", {tag, " data_avail after last bin"}, data_avail, 0);
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R6", {tag, " rd_valid single cycle"}, rd_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !data_avail && !rd_valid, "R1", "outputs in reset", {busy, data_avail, rd_valid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !data_avail && !rd_valid, "R1", "outputs after reset", {busy, data_avail, rd_valid}, 0);

    // R6: rd_next in idle has no effect
    rd_next = 1'b1;
    @(negedge clk);
    rd_next = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd_valid == 1'b0 && data_avail == 1'b0, "R6", "rd_next ignored in idle", rd_valid, 0);

    // Run 1 (R3, R5 sel 01, R8 noise during clear on code 9): table of bursts
    start_run(2'b01, 1'b1, 9);
    for (int e = 0; e < NB; e++) begin
      for (int r = 0; r < int'(RUN1[e][27:12]); r++) begin
        drive_one(int'(RUN1[e][11:0]), 1'b0);
        if (RUN1[e][28]) idle_one();
      end
    end
    idle_one();
    idle_one();
    chk(exp_cnt[100] == 2048 && exp_cnt[9] == 0 && exp_cnt[200] == 0, "R8",
        "model: halt bin, clear noise, post-halt samples", exp_cnt[100], 2048);
    read_all("run1");

    // Run 2 (R5 sel 00, R2 leftovers cleared, R8 start and max_sel while busy ignored)
    start_run(2'b00, 1'b0, 0);
    max_sel = 2'b01;
    for (int i = 0; i < 16400; i++) begin
      drive_one(4095, i == 8000);
      if (i == 8000)
        chk(busy == 1'b1 && data_avail == 1'b0, "R8", "start while counting ignored", busy, 1);
    end
    idle_one();
    idle_one();
    read_all("run2");

    // Run 3 (R5 sel 10): alternating codes, restart from the idle state
    start_run(2'b10, 1'b0, 0);
    for (int i = 0; i < 8200; i++) drive_one((i % 2 == 0) ? 1 : 2, 1'b0);
    idle_one();
    idle_one();
    read_all("run3");

    // Run 4 (R5 sel 11): single code, spaced every other cycle at the start
    start_run(2'b11, 1'b0, 0);
    for (int i = 0; i < 8200; i++) begin
      drive_one(3, 1'b0);
      if (i < 16) idle_one();
    end
    idle_one();
    idle_one();
    chk(exp_cnt[3] == 8192, "R5", "model cap for sel 11", exp_cnt[3], 8192);
    read_all("run4");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule